// File: doc/BRIEF.md
# Arithmetic and Lane-Extract Unit with Condition Flags

This block computes the register-to-register arithmetic group of a 32-bit integer datapath. It handles add, subtract, bitwise AND, OR and XOR, and two extract operations. The extract operations pull one byte or one 16-bit halfword out of operand A and zero-extend it. The lane is chosen by the low bits of operand B, and lane 0 is the least significant lane. The result is combinational and is valid in the same cycle as the inputs.

A four-bit flags register holds negative, zero, carry and overflow, in that order from the most significant bit down. It is loaded from the current result on a clock edge where the operation is valid and flag update is requested. A combinational condition output reads the stored flags and reports whether a selected branch condition holds.

Top module: `alu_extract`

## Requirements
- R1: Operation code 0 (ADD) gives `a + b` modulo 2^32. When flags are loaded, C is the carry out of bit 31 and V is signed overflow.
- R2: Operation code 1 (SUB) gives `a - b` modulo 2^32. When flags are loaded, C is 1 when no borrow occurs (`a >= b` unsigned) and V is signed overflow.
- R3: Operation codes 2 (AND), 3 (OR) and 4 (XOR) give the bitwise result. When flags are loaded, C and V become 0.
- R4: Operation code 5 (byte extract) returns byte `b[1:0]` of `a`, zero-extended, where byte 0 is bits 7:0. When flags are loaded, C and V become 0.
- R5: Operation code 6 (halfword extract) returns halfword `b[0]` of `a`, zero-extended, where halfword 0 is bits 15:0. When flags are loaded, C and V become 0.
- R6: The flags are {N,Z,C,V} at bits 3..0. N is set from result bit 31 and Z is set when the result is zero, for every defined operation.
- R7: The flags change only on a rising clock edge where both `valid` and `set_cc` are high. Otherwise they hold their value.
- R8: Reset (`rst_n` low, asynchronous) clears the flags to 0000.
- R9: Operation code 7 is reserved. It returns zero and never changes the flags.
- R10: `cond_true` is computed from the stored flags with these selector codes: 0 always, 1 never, 2 EQ (Z), 3 NE (!Z), 4 signed LT (N^V), 5 signed GE, 6 signed GT (!Z and N==V), 7 signed LE, 8 unsigned LO (!C), 9 unsigned HS (C).
- R11: Selector codes 10 to 15 give `cond_true` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation present this cycle |
| set_cc | input | 1 | Request to load the flags |
| op | input | 3 | Operation code |
| a | input | 32 | Left operand |
| b | input | 32 | Right operand or lane selector |
| cond_sel | input | 4 | Condition selector |
| result | output | 32 | Combinational result |
| flags | output | 4 | Stored {N,Z,C,V} |
| cond_true | output | 1 | Selected condition holds |

## Verification
Some properties are checked on every cycle. Flags hold unless a valid flag-setting operation occurs. Z tracks the result that was loaded. C and V clear after logical and extract operations. Reserved and unused codes have no effect. Only the bench scenarios can show correct numeric results, carry and overflow on chosen boundary operands, the lane ordering of the extracts, and the mapping of every condition selector.

// File: rtl/alu_extract.sv
module alu_extract #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         set_cc,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] result,
  output logic [3:0]   flags,
  output logic         cond_true
);
  localparam int BSEL = $clog2(W / 8);
  localparam int HSEL = $clog2(W / 16);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_EXB = 3'd5, OP_EXH = 3'd6;

  logic         is_sub;
  logic [W-1:0] b_in, byte_sh, half_sh;
  logic [W:0]   sum;
  logic         carry, ovf, arith, load_cc;

  assign is_sub  = (op == OP_SUB);
  assign b_in    = is_sub ? ~b : b;
  assign sum     = {1'b0, a} + {1'b0, b_in} + {{W{1'b0}}, is_sub};
  assign carry   = sum[W];
  assign ovf     = (a[W-1] == b_in[W-1]) && (sum[W-1] != a[W-1]);
  assign arith   = (op == OP_ADD) || is_sub;
  assign byte_sh = a >> {b[BSEL-1:0], 3'b000};
  assign half_sh = a >> {b[HSEL-1:0], 4'b0000};
  assign load_cc = valid && set_cc && (op != 3'd7);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: result = sum[W-1:0];
      OP_AND:         result = a & b;
      OP_OR:          result = a | b;
      OP_XOR:         result = a ^ b;
      OP_EXB:         result = {{(W-8){1'b0}}, byte_sh[7:0]};
      OP_EXH:         result = {{(W-16){1'b0}}, half_sh[15:0]};
      default:        result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= 4'b0000;
    else if (load_cc) flags <= {result[W-1], result == '0, arith & carry, arith & ovf};
  end

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags;

  always_comb begin
    case (cond_sel)
      4'd0:    cond_true = 1'b1;
      4'd2:    cond_true = fz;
      4'd3:    cond_true = !fz;
      4'd4:    cond_true = fn ^ fv;
      4'd5:    cond_true = !(fn ^ fv);
      4'd6:    cond_true = !fz && (fn == fv);
      4'd7:    cond_true = fz || (fn != fv);
      4'd8:    cond_true = !fc;
      4'd9:    cond_true = fc;
      default: cond_true = 1'b0;
    endcase
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && set_cc) |=> $stable(flags));
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd7) |=> $stable(flags));
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && set_cc && op != 3'd7) |=> (flags[2] == ($past(result) == '0)));
  p_cv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && set_cc && op inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6}) |=> (flags[1:0] == 2'b00));
  p_extb_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EXB) |-> (result[W-1:8] == '0));
  p_never_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd1 || cond_sel >= 4'd10) |-> !cond_true);
endmodule

// File: tb/alu_extract_tb_top.sv
module alu_extract_tb_top;
  logic clk = 0, rst_n = 0, valid = 0, set_cc = 0, cond_true;
  logic [2:0] op = 0;
  logic [31:0] a = 0, b = 0, result;
  logic [3:0] cond_sel = 0, flags;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu_extract dut_i (.clk(clk), .rst_n(rst_n), .valid(valid), .set_cc(set_cc), .op(op),
    .a(a), .b(b), .cond_sel(cond_sel), .result(result), .flags(flags), .cond_true(cond_true));

  localparam int NV = 17;
  localparam logic [2:0]  V_OP [NV] = '{0,0,0,1,1,1,1,2,3,4,5,5,5,5,6,6,6};
  localparam logic [31:0] V_A  [NV] = '{32'd1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'd5, 32'd3,
    32'h80000000, 32'd5, 32'hF0F0F0F0, 32'h0, 32'h12345678, 32'hAABBCCDD, 32'hAABBCCDD,
    32'hAABBCCDD, 32'h00FF0000, 32'hAABBCCDD, 32'hAABBCCDD, 32'h8000_1234};
  localparam logic [31:0] V_B  [NV] = '{32'd2, 32'd1, 32'd1, 32'd3, 32'd5, 32'd1, 32'd5,
    32'hFF00FF00, 32'h0, 32'hFFFFFFFF, 32'd0, 32'd3, 32'hFFFFFFFE, 32'd1, 32'd1, 32'd2, 32'd3};
  localparam logic [31:0] V_R  [NV] = '{32'd3, 32'd0, 32'h80000000, 32'd2, 32'hFFFFFFFE,
    32'h7FFFFFFF, 32'd0, 32'hF000F000, 32'h0, 32'hEDCBA987, 32'hDD, 32'hAA, 32'hBB, 32'h0,
    32'hAABB, 32'hCCDD, 32'h8000};
  localparam logic [3:0]  V_F  [NV] = '{4'b0000, 4'b0110, 4'b1001, 4'b0010, 4'b1000, 4'b0011,
    4'b0110, 4'b1000, 4'b0100, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b0000,
    4'b0000, 4'b0000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic v, input logic s);
    @(negedge clk);
    op = o; a = x; b = y; valid = v; set_cc = s;
    #1;
  endtask

  task automatic settle();
    @(posedge clk); #1;
    valid = 0; set_cc = 0;
  endtask

  task automatic cond(input logic [3:0] sel, input logic exp, input string req);
    @(negedge clk); cond_sel = sel; #1;
    chk(req, {31'b0, cond_true}, {31'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset flags", {28'b0, flags}, 32'h0);
    cond(4'd0, 1, "R10 always");
    cond(4'd8, 1, "R10 LO after reset");
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      run(V_OP[i], V_A[i], V_B[i], 1, 1);
      chk(V_OP[i] < 2 ? "R1 R2 result" : V_OP[i] < 5 ? "R3 result" :
          V_OP[i] == 5 ? "R4 extract byte" : "R5 extract half", result, V_R[i]);
      settle();
      chk("R6 flags NZCV", {28'b0, flags}, {28'b0, V_F[i]});
    end

    run(3'd1, 32'd5, 32'd5, 1, 1); settle();
    run(3'd1, 32'd3, 32'd5, 1, 0); settle();
    chk("R7 set_cc low holds", {28'b0, flags}, 32'h6);
    run(3'd1, 32'd3, 32'd5, 0, 1); settle();
    chk("R7 valid low holds", {28'b0, flags}, 32'h6);
    run(3'd7, 32'hFFFFFFFF, 32'd1, 1, 1);
    chk("R9 reserved result", result, 32'h0);
    settle();
    chk("R9 reserved flags", {28'b0, flags}, 32'h6);
    cond(4'd2, 1, "R10 EQ");
    cond(4'd3, 0, "R10 NE");

    run(3'd1, 32'd3, 32'd5, 1, 1); settle();
    cond(4'd4, 1, "R10 LT");
    cond(4'd5, 0, "R10 GE");
    cond(4'd6, 0, "R10 GT");
    cond(4'd7, 1, "R10 LE");
    cond(4'd8, 1, "R10 LO");
    cond(4'd9, 0, "R10 HS");
    cond(4'd1, 0, "R11 never");
    run(3'd1, 32'd5, 32'd3, 1, 1); settle();
    cond(4'd6, 1, "R10 GT");
    cond(4'd7, 0, "R10 LE");
    cond(4'd9, 1, "R10 HS");
    cond(4'd5, 1, "R10 GE");
    cond(4'd0, 1, "R10 always");
    for (int s = 10; s < 16; s++) cond(4'(s), 0, "R11 unused selector");

    @(negedge clk); rst_n = 0; #1;
    chk("R8 async reset", {28'b0, flags}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; errors++; $display("FAIL watchdog expired"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule